// File: doc/BRIEF.md
# Branch Predictor with Return Stack

This unit sits in the fetch path and produces a next-fetch prediction within the same cycle. Each cycle the fetch stage presents a PC. It also presents predecode information for the branch found at that PC: the branch kind, whether its displacement points backward, the target encoded in the instruction, and the instruction length. From these the unit returns whether the prediction is valid, whether the branch is predicted taken, and the address to fetch next. When the branch is not taken, that address is the fall-through PC plus length.

Dynamic state has three parts. A direct-mapped, tagged target buffer is indexed by the low PC bits. A table of 2-bit saturating counters shares that index. A circular return stack holds return addresses. When the target buffer has no entry for a conditional branch, a static rule applies: backward branches are predicted taken and forward ones not taken. Far transfers are never predicted. The target buffer and the counters change only through a separate retirement port. The return stack is pushed and popped at prediction time.

Top module: `branch_predictor`

## Requirements
- R1: The lookupKind codes are 0 conditional, 1 call, 2 return, 3 direct jump and 4 indirect jump. Codes 5, 6 and 7 are far transfers: predValid=0, predTaken=0, predTarget = lookupPc + lookupLen, and the return stack is left untouched.
- R2: A conditional branch that misses the target buffer gives predValid=1. If lookupBackward=1 it predicts taken to lookupTarget. Otherwise it predicts not taken to the fall-through address.
- R3: A conditional branch that hits the target buffer is predicted taken exactly when its counter is 2 or 3. When taken, the target is the stored target; when not taken, it is the fall-through.
- R4: Each counter resets to 1 (weakly not taken). Retiring a conditional branch increments its counter when taken and decrements it when not taken, saturating at 3 and at 0.
- R5: Target-buffer entries are written only by retiring a taken conditional, call, direct-jump or indirect branch. A lookup whose index matches but whose upper PC bits differ is a miss. Lookups never alter the target buffer or the counters.
- R6: A call predicts taken to the stored target on a hit, or to lookupTarget on a miss, and pushes lookupPc + lookupLen.
- R7: A return on a non-empty stack predicts taken to the top entry, sets predFromStack=1 and pops.
- R8: A return on an empty stack gives predFromStack=0 and the most recently popped value (0 after reset). The stack pointer does not move.
- R9: The stack holds 16 entries. A push when full overwrites the oldest entry, so the newest 16 come back in reverse order.
- R10: A direct jump predicts taken to the stored target or to lookupTarget. An indirect jump predicts taken to the stored target on a hit, and not taken to the fall-through on a miss.
- R11: A retirement in the same cycle as a lookup to the same entry does not affect that lookup. It takes effect for the next one.
- R12: With lookupValid=0, predValid=0 and the return stack does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A branch is present at lookupPc |
| lookupPc | input | 32 | Fetch PC of the branch |
| lookupKind | input | 3 | Predecoded branch kind |
| lookupBackward | input | 1 | Displacement points backward |
| lookupTarget | input | 32 | Target encoded in the instruction |
| lookupLen | input | 4 | Instruction length in bytes |
| retValid | input | 1 | A branch retires this cycle |
| retPc | input | 32 | PC of the retiring branch |
| retKind | input | 3 | Kind of the retiring branch |
| retTaken | input | 1 | Resolved direction |
| retTarget | input | 32 | Resolved target |
| predValid | output | 1 | A prediction is offered |
| predTaken | output | 1 | Predicted direction |
| predTarget | output | 32 | Next fetch address |
| predFromStack | output | 1 | Return target came from a live stack entry |

## Verification
The assertions assume that lookupKind and retKind are held to the listed codes. They also assume the control never requests a push and a pop in the same cycle, and that the stack depth is a power of two so the pointer wraps cleanly. The stimulus changes inputs only at the falling edge and offers at most one lookup and one retirement per cycle. It retires only branches whose outcome it has chosen itself, so every expected counter value and stack content follows directly from the sequence the bench applies.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [2:0] {
    KIND_COND  = 3'd0,
    KIND_CALL  = 3'd1,
    KIND_RET   = 3'd2,
    KIND_JUMP  = 3'd3,
    KIND_INDIR = 3'd4,
    KIND_FAR   = 3'd5
  } brKind_e;

  typedef enum logic [1:0] {
    SEL_FALL   = 2'd0,
    SEL_STATIC = 2'd1,
    SEL_BTB    = 2'd2,
    SEL_RAS    = 2'd3
  } tgtSel_e;

  typedef struct packed {
    logic    rasPush;
    logic    rasPop;
    logic    btbWrite;
    logic    histUp;
    logic    histDown;
    tgtSel_e tgtSel;
  } bpStrobe_t;
endpackage

// File: rtl/bp_control.sv
module bp_control
  import bp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lookupValid,
  input  logic [2:0] lookupKind,
  input  logic       lookupBackward,
  input  logic       btbHit,
  input  logic       histTaken,
  input  logic       rasNonEmpty,
  input  logic       retValid,
  input  logic [2:0] retKind,
  input  logic       retTaken,
  output bpStrobe_t  strobes,
  output logic       predValid,
  output logic       predTaken,
  output logic       predFromStack
);
  brKind_e lkKind;
  brKind_e rtKind;
  logic    rtNearTarget;

  assign lkKind = brKind_e'(lookupKind);
  assign rtKind = brKind_e'(retKind);
  assign rtNearTarget = (rtKind == KIND_COND) || (rtKind == KIND_CALL) ||
                        (rtKind == KIND_JUMP) || (rtKind == KIND_INDIR);

  always_comb begin
    strobes       = '0;
    strobes.tgtSel = SEL_FALL;
    predValid     = 1'b0;
    predTaken     = 1'b0;
    predFromStack = 1'b0;
    if (lookupValid) begin
      case (lkKind)
        KIND_COND: begin
          predValid = 1'b1;
          predTaken = btbHit ? histTaken : lookupBackward;
          if (btbHit) strobes.tgtSel = histTaken ? SEL_BTB : SEL_FALL;
          else        strobes.tgtSel = lookupBackward ? SEL_STATIC : SEL_FALL;
        end
        KIND_CALL: begin
          predValid       = 1'b1;
          predTaken       = 1'b1;
          strobes.rasPush = 1'b1;
          strobes.tgtSel  = btbHit ? SEL_BTB : SEL_STATIC;
        end
        KIND_RET: begin
          predValid      = 1'b1;
          predTaken      = 1'b1;
          predFromStack  = rasNonEmpty;
          strobes.rasPop = 1'b1;
          strobes.tgtSel = SEL_RAS;
        end
        KIND_JUMP: begin
          predValid      = 1'b1;
          predTaken      = 1'b1;
          strobes.tgtSel = btbHit ? SEL_BTB : SEL_STATIC;
        end
        KIND_INDIR: begin
          predValid      = 1'b1;
          predTaken      = btbHit;
          strobes.tgtSel = btbHit ? SEL_BTB : SEL_FALL;
        end
        default: ;
      endcase
    end
    if (retValid) begin
      strobes.histUp   = (rtKind == KIND_COND) && retTaken;
      strobes.histDown = (rtKind == KIND_COND) && !retTaken;
      strobes.btbWrite = retTaken && rtNearTarget;
    end
  end

  AST_FAR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (lookupValid && lookupKind >= 3'd5) |-> (!predValid && !strobes.rasPush && !strobes.rasPop)); // R1
  AST_IDLE_NO_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    !lookupValid |-> (!strobes.rasPush && !strobes.rasPop && !predValid)); // R12
  AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.rasPush && strobes.rasPop)); // R9
endmodule

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int BTB_N = 64,
  parameter int RAS_N = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  bpStrobe_t       strobes,
  input  logic [PC_W-1:0] fetchPc,
  input  logic [3:0]      instLen,
  input  logic [PC_W-1:0] staticTarget,
  input  logic [PC_W-1:0] retPc,
  input  logic [PC_W-1:0] retTarget,
  output logic            btbHit,
  output logic            histTaken,
  output logic            rasNonEmpty,
  output logic [PC_W-1:0] predTarget
);
  localparam int IDX_W = $clog2(BTB_N);
  localparam int TAG_W = PC_W - IDX_W;
  localparam int PTR_W = $clog2(RAS_N);
  localparam int CNT_W = PTR_W + 1;

  logic [BTB_N-1:0]      btbValid;
  logic [TAG_W-1:0]      btbTag [BTB_N];
  logic [PC_W-1:0]       btbTgt [BTB_N];
  logic [BTB_N-1:0][1:0] hist;
  logic [PC_W-1:0]       ras [RAS_N];
  logic [PTR_W-1:0]      ptr;
  logic [CNT_W-1:0]      cnt;

  logic [IDX_W-1:0] lkIdx, rtIdx;
  logic [TAG_W-1:0] lkTag;
  logic [PC_W-1:0]  fallThrough, rasTop;
  logic [PTR_W-1:0] ptrPrev;

  assign lkIdx       = fetchPc[IDX_W-1:0];
  assign lkTag       = fetchPc[PC_W-1:IDX_W];
  assign rtIdx       = retPc[IDX_W-1:0];
  assign fallThrough = fetchPc + {{(PC_W-4){1'b0}}, instLen};
  assign ptrPrev     = ptr - 1'b1;
  assign rasNonEmpty = (cnt != '0);
  assign rasTop      = rasNonEmpty ? ras[ptrPrev] : ras[ptr];
  assign btbHit      = btbValid[lkIdx] && (btbTag[lkIdx] == lkTag);
  assign histTaken   = hist[lkIdx][1];

  always_comb begin
    case (strobes.tgtSel)
      SEL_STATIC: predTarget = staticTarget;
      SEL_BTB:    predTarget = btbTgt[lkIdx];
      SEL_RAS:    predTarget = rasTop;
      default:    predTarget = fallThrough;
    endcase
  end

  // Retirement-side tables
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      btbValid <= '0;
      for (int i = 0; i < BTB_N; i++) hist[i] <= 2'b01;
    end else begin
      if (strobes.btbWrite) btbValid[rtIdx] <= 1'b1;
      if (strobes.histUp && hist[rtIdx] != 2'b11) hist[rtIdx] <= hist[rtIdx] + 2'd1;
      else if (strobes.histDown && hist[rtIdx] != 2'b00) hist[rtIdx] <= hist[rtIdx] - 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.btbWrite) begin
      btbTag[rtIdx] <= retPc[PC_W-1:IDX_W];
      btbTgt[rtIdx] <= retTarget;
    end
  end

  // Circular return stack; depth must be a power of two
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      cnt <= '0;
      for (int i = 0; i < RAS_N; i++) ras[i] <= '0;
    end else if (strobes.rasPush) begin
      ras[ptr] <= fallThrough;
      ptr      <= ptr + 1'b1;
      if (cnt != CNT_W'(RAS_N)) cnt <= cnt + 1'b1;
    end else if (strobes.rasPop && rasNonEmpty) begin
      ptr <= ptrPrev;
      cnt <= cnt - 1'b1;
    end
  end

  AST_TABLES_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.btbWrite && !strobes.histUp && !strobes.histDown) |=> ($stable(btbValid) && $stable(hist))); // R5
  AST_CTR_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.histUp && hist[rtIdx] == 2'b11) |=> (hist[$past(rtIdx)] == 2'b11)); // R4
  AST_CTR_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.histDown && hist[rtIdx] == 2'b00) |=> (hist[$past(rtIdx)] == 2'b00)); // R4
  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.rasPush |=> (rasNonEmpty && ras[ptr - 1'b1] == $past(fallThrough))); // R6
  AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.rasPush && cnt == CNT_W'(RAS_N)) |=> (cnt == CNT_W'(RAS_N))); // R9
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.rasPop && !rasNonEmpty) |=> (cnt == '0 && $stable(ptr))); // R8
endmodule

// File: rtl/branch_predictor.sv
module branch_predictor
  import bp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int BTB_N = 64,
  parameter int RAS_N = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lookupValid,
  input  logic [PC_W-1:0] lookupPc,
  input  logic [2:0]      lookupKind,
  input  logic            lookupBackward,
  input  logic [PC_W-1:0] lookupTarget,
  input  logic [3:0]      lookupLen,
  input  logic            retValid,
  input  logic [PC_W-1:0] retPc,
  input  logic [2:0]      retKind,
  input  logic            retTaken,
  input  logic [PC_W-1:0] retTarget,
  output logic            predValid,
  output logic            predTaken,
  output logic [PC_W-1:0] predTarget,
  output logic            predFromStack
);
  bpStrobe_t strobes;
  logic      btbHit, histTaken, rasNonEmpty;

  bp_control u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .lookupValid(lookupValid), .lookupKind(lookupKind), .lookupBackward(lookupBackward),
    .btbHit(btbHit), .histTaken(histTaken), .rasNonEmpty(rasNonEmpty),
    .retValid(retValid), .retKind(retKind), .retTaken(retTaken),
    .strobes(strobes), .predValid(predValid), .predTaken(predTaken),
    .predFromStack(predFromStack)
  );

  bp_datapath #(.PC_W(PC_W), .BTB_N(BTB_N), .RAS_N(RAS_N)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .fetchPc(lookupPc), .instLen(lookupLen), .staticTarget(lookupTarget),
    .retPc(retPc), .retTarget(retTarget),
    .btbHit(btbHit), .histTaken(histTaken), .rasNonEmpty(rasNonEmpty),
    .predTarget(predTarget)
  );
endmodule

// File: tb/branch_predictor_tb.sv
`timescale 1ns/1ps
module branch_predictor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupPc = '0;
  logic [2:0]  lookupKind = '0;
  logic        lookupBackward = 1'b0;
  logic [31:0] lookupTarget = '0;
  logic [3:0]  lookupLen = '0;
  logic        retValid = 1'b0;
  logic [31:0] retPc = '0;
  logic [2:0]  retKind = '0;
  logic        retTaken = 1'b0;
  logic [31:0] retTarget = '0;
  logic        predValid, predTaken, predFromStack;
  logic [31:0] predTarget;

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  branch_predictor u_dut (
    .clk(clk), .rst_n(rst_n),
    .lookupValid(lookupValid), .lookupPc(lookupPc), .lookupKind(lookupKind),
    .lookupBackward(lookupBackward), .lookupTarget(lookupTarget), .lookupLen(lookupLen),
    .retValid(retValid), .retPc(retPc), .retKind(retKind), .retTaken(retTaken),
    .retTarget(retTarget),
    .predValid(predValid), .predTaken(predTaken), .predTarget(predTarget),
    .predFromStack(predFromStack)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  kind;
    logic        bwd;
    logic [31:0] pc;
    logic [31:0] tgt;
    logic [3:0]  len;
    logic        eValid;
    logic        eTaken;
    logic [31:0] eTgt;
  } vec_t;

  // Fresh-state lookups, all target-buffer misses
  localparam vec_t VECS [0:5] = '{
    '{4'd2,  3'd0, 1'b1, 32'h0000_1010, 32'h0000_0F00, 4'd2, 1'b1, 1'b0 | 1'b1, 32'h0000_0F00}, // R2 backward
    '{4'd2,  3'd0, 1'b0, 32'h0000_1020, 32'h0000_1080, 4'd6, 1'b1, 1'b0, 32'h0000_1026},        // R2 forward
    '{4'd1,  3'd5, 1'b1, 32'h0000_1030, 32'h0000_5000, 4'd7, 1'b0, 1'b0, 32'h0000_1037},        // R1 far
    '{4'd1,  3'd7, 1'b0, 32'h0000_1040, 32'h0000_6000, 4'd4, 1'b0, 1'b0, 32'h0000_1044},        // R1 code 7
    '{4'd10, 3'd3, 1'b0, 32'h0000_1050, 32'h0000_2222, 4'd5, 1'b1, 1'b1, 32'h0000_2222},        // R10 direct jump
    '{4'd10, 3'd4, 1'b0, 32'h0000_1060, 32'h0000_DEAD, 4'd3, 1'b1, 1'b0, 32'h0000_1063}         // R10 indirect miss
  };

  function automatic string reqName(input logic [3:0] n);
    case (n)
      4'd1:    return "R1";
      4'd2:    return "R2";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic look(input logic [2:0] k, input logic [31:0] pc, input logic bwd,
                      input logic [31:0] tgt, input logic [3:0] len,
                      input logic eV, input logic eT, input logic [31:0] eTgt,
                      input logic eS, input string req);
    lookupValid = 1'b1; lookupKind = k; lookupPc = pc;
    lookupBackward = bwd; lookupTarget = tgt; lookupLen = len;
    #1;
    chk(req, "predValid", {31'b0, predValid}, {31'b0, eV});
    chk(req, "predTaken", {31'b0, predTaken}, {31'b0, eT});
    chk(req, "predTarget", predTarget, eTgt);
    chk(req, "predFromStack", {31'b0, predFromStack}, {31'b0, eS});
    @(negedge clk);
    lookupValid = 1'b0;
  endtask

  task automatic retire(input logic [2:0] k, input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
    retValid = 1'b1; retKind = k; retPc = pc; retTaken = tk; retTarget = tgt;
    @(negedge clk);
    retValid = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  localparam logic [31:0] P0 = 32'h1000_0040;

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "reset predValid", {31'b0, predValid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: empty stack after reset yields 0 and no live entry
    look(3'd2, 32'h0000_0100, 1'b0, 32'h0, 4'd1, 1'b1, 1'b1, 32'h0, 1'b0, "R8");

    for (int i = 0; i < 6; i++)
      look(VECS[i].kind, VECS[i].pc, VECS[i].bwd, VECS[i].tgt, VECS[i].len,
           VECS[i].eValid, VECS[i].eTaken, VECS[i].eTgt, 1'b0, reqName(VECS[i].req));

    // R3 / R4: counter walk at P0 (forward conditional, fall-through P0+4)
    retire(3'd0, P0, 1'b1, 32'h0000_2000);
    look(3'd0, P0, 1'b0, 32'h1000_0080, 4'd4, 1'b1, 1'b1, 32'h0000_2000, 1'b0, "R3");
    retire(3'd0, P0, 1'b0, 32'h0);
    look(3'd0, P0, 1'b0, 32'h1000_0080, 4'd4, 1'b1, 1'b0, P0 + 4, 1'b0, "R3");
    retire(3'd0, P0, 1'b0, 32'h0);
    retire(3'd0, P0, 1'b0, 32'h0);
    retire(3'd0, P0, 1'b0, 32'h0);
    retire(3'd0, P0, 1'b1, 32'h0000_2000);
    look(3'd0, P0, 1'b0, 32'h1000_0080, 4'd4, 1'b1, 1'b0, P0 + 4, 1'b0, "R4 low saturation");
    retire(3'd0, P0, 1'b1, 32'h0000_2000);
    look(3'd0, P0, 1'b0, 32'h1000_0080, 4'd4, 1'b1, 1'b1, 32'h0000_2000, 1'b0, "R4");
    retire(3'd0, P0, 1'b1, 32'h0000_2000);
    retire(3'd0, P0, 1'b1, 32'h0000_2000);
    retire(3'd0, P0, 1'b0, 32'h0);
    look(3'd0, P0, 1'b0, 32'h1000_0080, 4'd4, 1'b1, 1'b1, 32'h0000_2000, 1'b0, "R4 high saturation");
    retire(3'd0, P0, 1'b0, 32'h0);
    look(3'd0, P0, 1'b0, 32'h1000_0080, 4'd4, 1'b1, 1'b0, P0 + 4, 1'b0, "R4");

    // R5: tag mismatch, return never allocates, not-taken never allocates
    look(3'd0, 32'h2000_0040, 1'b0, 32'h0, 4'd4, 1'b1, 1'b0, 32'h2000_0044, 1'b0, "R5 tag");
    retire(3'd2, 32'h3000_0007, 1'b1, 32'h0000_0999);
    look(3'd3, 32'h3000_0007, 1'b0, 32'h0000_0111, 4'd2, 1'b1, 1'b1, 32'h0000_0111, 1'b0, "R5 return retire");
    retire(3'd0, 32'h3000_0009, 1'b0, 32'h0000_0777);
    look(3'd0, 32'h3000_0009, 1'b1, 32'h0000_0050, 4'd2, 1'b1, 1'b1, 32'h0000_0050, 1'b0, "R5 not-taken retire");

    // R11: retirement in the same cycle as a lookup to the same entry
    retValid = 1'b1; retKind = 3'd0; retPc = 32'h4000_0005; retTaken = 1'b1; retTarget = 32'h0000_0500;
    look(3'd0, 32'h4000_0005, 1'b1, 32'h0000_0100, 4'd2, 1'b1, 1'b1, 32'h0000_0100, 1'b0, "R11 same cycle");
    retValid = 1'b0;
    look(3'd0, 32'h4000_0005, 1'b1, 32'h0000_0100, 4'd2, 1'b1, 1'b1, 32'h0000_0500, 1'b0, "R11 next");

    // R10: indirect jump learns its target
    look(3'd4, 32'h5000_000C, 1'b0, 32'h0, 4'd2, 1'b1, 1'b0, 32'h5000_000E, 1'b0, "R10 miss");
    retire(3'd4, 32'h5000_000C, 1'b1, 32'h0000_7000);
    look(3'd4, 32'h5000_000C, 1'b0, 32'h0, 4'd2, 1'b1, 1'b1, 32'h0000_7000, 1'b0, "R10 hit");

    // R6 / R7 / R8: call, return, empty returns
    look(3'd1, 32'h6000_0100, 1'b0, 32'h6000_0900, 4'd5, 1'b1, 1'b1, 32'h6000_0900, 1'b0, "R6");
    look(3'd2, 32'h6000_0900, 1'b0, 32'h0, 4'd1, 1'b1, 1'b1, 32'h6000_0105, 1'b1, "R7");
    look(3'd2, 32'h6000_0901, 1'b0, 32'h0, 4'd1, 1'b1, 1'b1, 32'h6000_0105, 1'b0, "R8 empty");
    look(3'd2, 32'h6000_0902, 1'b0, 32'h0, 4'd1, 1'b1, 1'b1, 32'h6000_0105, 1'b0, "R8 pointer held");

    // R1 / R12: far lookup and idle cycle leave the stack alone
    look(3'd1, 32'h6000_0200, 1'b0, 32'h6000_0A00, 4'd3, 1'b1, 1'b1, 32'h6000_0A00, 1'b0, "R6");
    look(3'd5, 32'h6000_0300, 1'b0, 32'h0, 4'd2, 1'b0, 1'b0, 32'h6000_0302, 1'b0, "R1");
    lookupKind = 3'd2;
    #1;
    chk("R12", "idle predValid", {31'b0, predValid}, 32'd0);
    @(negedge clk);
    look(3'd2, 32'h6000_0A00, 1'b0, 32'h0, 4'd1, 1'b1, 1'b1, 32'h6000_0203, 1'b1, "R12 stack intact");
    look(3'd2, 32'h6000_0A01, 1'b0, 32'h0, 4'd1, 1'b1, 1'b1, 32'h6000_0203, 1'b0, "R1 no push");

    // R9: seventeen calls, newest sixteen return in reverse order
    for (int i = 0; i < 17; i++)
      look(3'd1, 32'h8000_0000 + 32'(i) * 32'h40, 1'b0, 32'h0000_9000, 4'd4,
           1'b1, 1'b1, 32'h0000_9000, 1'b0, "R9 call");
    for (int k = 0; k < 16; k++)
      look(3'd2, 32'h0000_9000, 1'b0, 32'h0, 4'd1, 1'b1, 1'b1,
           32'h8000_0004 + 32'(16 - k) * 32'h40, 1'b1, "R9 return");
    look(3'd2, 32'h0000_9000, 1'b0, 32'h0, 4'd1, 1'b1, 1'b1, 32'h8000_0044, 1'b0, "R9 drained");

    summary();
  end
endmodule